// File: doc/BRIEF.md
# Per-Stage Instruction Class Tracker

This block follows one chosen class of instruction through a five-stage in-order pipeline: fetch, decode, execute, memory and writeback. Each stage gets a presence flag. The flag is high only while that stage holds an instruction of the tracked class. Next to each flag the block drives an enable for logic that lies outside the tracked instruction's slice. The surrounding design can use that enable to quiet such logic, for example a floating-point unit while an integer add is executing.

The fetch flag is decoded from the opcode field of the fetched word. It is qualified by reset, pipeline flush and the fetch freeze. Each later stage takes the previous stage's flag from one clock earlier and qualifies it with its own freeze input. A frozen stage therefore never claims the tracked instruction, and its out-of-slice logic stays enabled. The opcode value, opcode mask and field position are parameters, so the same structure can track any other class.

Top module: `stage_slice_tracker`

## Requirements
- R1: While `rst` is high, every bit of `stageHit` is 0 and every bit of `outEnable` is 1. The clear is synchronous and also applies to the held stage state, so the first cycle after reset shows no stale flags.
- R2: With `rst`, `flushPipe` and `freezeIn[0]` low, `stageHit[0]` is 1 exactly when `instrWord[31:26]` equals 6'b111000 under the default all-ones mask. Any other opcode gives 0.
- R3: A high `flushPipe` or a high `freezeIn[0]` forces `stageHit[0]` to 0 in the same cycle, whatever the opcode.
- R4: For stage k in 1..4 (bit 1 decode, bit 2 execute, bit 3 memory, bit 4 writeback), `stageHit[k]` in a cycle equals `stageHit[k-1]` of the previous cycle AND NOT `freezeIn[k]` of the current cycle.
- R5: Freezing a stage drops the tracked token instead of holding it. The frozen stage's flag is 0, and the next stage's flag is 0 in the following cycle whatever that stage's freeze input is.
- R6: `outEnable[k]` is the inverse of `stageHit[k]` for every stage. A datapath that gates out-of-slice logic with these enables produces the same results as one that does not.
- R7: Tracked instructions fetched in consecutive cycles are followed independently. Several stage flags can be high at once, each moving one stage per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instrWord | input | 32 | Instruction word presented at fetch |
| flushPipe | input | 1 | Pipeline flush, suppresses entry at fetch |
| freezeIn | input | 5 | Per-stage freeze, bit 0 fetch to bit 4 writeback |
| stageHit | output | 5 | Stage holds the tracked class, bit 0 fetch to bit 4 writeback |
| outEnable | output | 5 | Enable for out-of-slice logic per stage, active high |

## Verification
The hardest situation to reach from the ports is a dense mix: tracked instructions fetched back to back, with freezes landing on some stages while tokens occupy others. Only then do the per-stage drops and the token movement interact. The stimulus makes about a third of the fetched words tracked opcodes and gives each freeze bit an independent one-in-eight chance per cycle. Directed sequences also place a single freeze on the execute stage while tokens sit both before and behind it. A bench-side floating-point accumulator is run once with and once without the execute enable, to show that gating changes no results.

// File: rtl/slice_pkg.sv
package slice_pkg;

  // Pipeline depth tracked by the block
  parameter int STAGES = 5;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } stage_e;

  // Strobes from the control half to the flag chain
  typedef struct packed {
    logic              clear;             // synchronous reset of held state
    logic              enter;             // qualified opcode hit at fetch
    logic [STAGES-1:1] keep;              // per-stage pass permission
  } slice_strobe_t;

endpackage

// File: rtl/slice_ctrl.sv
module slice_ctrl
  import slice_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter int              OP_LSB   = 26,
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_MATCH = 6'b111000,
  parameter logic [OP_W-1:0] OP_MASK  = 6'b111111
) (
  input  logic              rst,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              flushPipe,
  input  logic [STAGES-1:0] freezeIn,
  output slice_strobe_t     strobes
);

  localparam int OP_MSB = OP_LSB + OP_W - 1;

  logic [OP_W-1:0] opField;
  logic            opHit;
  logic            unusedLowBits;

  assign opField       = instrWord[OP_MSB:OP_LSB];
  assign unusedLowBits = ^instrWord[OP_LSB-1:0];
  assign opHit         = ((opField & OP_MASK) == (OP_MATCH & OP_MASK));

  always_comb begin
    strobes.clear = rst;
    strobes.enter = opHit & ~rst & ~flushPipe & ~freezeIn[ST_FETCH];
    for (int k = 1; k < STAGES; k++) begin
      strobes.keep[k] = ~rst & ~freezeIn[k];
    end
  end

endmodule

// File: rtl/slice_path.sv
module slice_path
  import slice_pkg::*;
(
  input  logic              clk,
  input  slice_strobe_t     strobes,
  output logic [STAGES-1:0] stageHit,
  output logic [STAGES-1:0] outEnable
);

  // heldFlag[k] is the previous stage's flag, captured one clock earlier
  logic [STAGES-1:1] heldFlag;

  assign stageHit[ST_FETCH] = strobes.enter;

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (strobes.clear) heldFlag[k] <= 1'b0;
        else               heldFlag[k] <= stageHit[k-1];
      end
      assign stageHit[k] = heldFlag[k] & strobes.keep[k];
    end
  endgenerate

  assign outEnable = ~stageHit;

endmodule

// File: rtl/stage_slice_tracker.sv
module stage_slice_tracker
  import slice_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter int              OP_LSB   = 26,
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_MATCH = 6'b111000,
  parameter logic [OP_W-1:0] OP_MASK  = 6'b111111
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              flushPipe,
  input  logic [STAGES-1:0] freezeIn,
  output logic [STAGES-1:0] stageHit,
  output logic [STAGES-1:0] outEnable
);

  slice_strobe_t strobes;

  slice_ctrl #(
    .WORD_W  (WORD_W),
    .OP_LSB  (OP_LSB),
    .OP_W    (OP_W),
    .OP_MATCH(OP_MATCH),
    .OP_MASK (OP_MASK)
  ) ctrl_i (
    .rst      (rst),
    .instrWord(instrWord),
    .flushPipe(flushPipe),
    .freezeIn (freezeIn),
    .strobes  (strobes)
  );

  slice_path path_i (
    .clk      (clk),
    .strobes  (strobes),
    .stageHit (stageHit),
    .outEnable(outEnable)
  );

endmodule

// File: rtl/slice_tracker_chk.sv
module slice_tracker_chk
  import slice_pkg::*;
#(
  parameter int              WORD_W   = 32,
  parameter int              OP_LSB   = 26,
  parameter int              OP_W     = 6,
  parameter logic [OP_W-1:0] OP_MATCH = 6'b111000,
  parameter logic [OP_W-1:0] OP_MASK  = 6'b111111
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instrWord,
  input logic              flushPipe,
  input logic [STAGES-1:0] freezeIn,
  input logic [STAGES-1:0] stageHit,
  input logic [STAGES-1:0] outEnable
);

  localparam int OP_MSB = OP_LSB + OP_W - 1;

  logic opSeen;
  assign opSeen = ((instrWord[OP_MSB:OP_LSB] & OP_MASK) == (OP_MATCH & OP_MASK));

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> (stageHit == '0) && (outEnable == '1)); // R1

  AST_FETCH_NEEDS_OP: assert property (@(posedge clk) disable iff (rst)
    stageHit[ST_FETCH] |-> opSeen); // R2

  AST_FETCH_OP_ENTERS: assert property (@(posedge clk) disable iff (rst)
    (opSeen && !flushPipe && !freezeIn[ST_FETCH]) |-> stageHit[ST_FETCH]); // R2

  AST_FETCH_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (flushPipe || freezeIn[ST_FETCH]) |-> !stageHit[ST_FETCH]); // R3

  AST_ENABLE_COMPLEMENT: assert property (@(posedge clk)
    $countones(stageHit & outEnable) == 0 && (stageHit | outEnable) == '1); // R6

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_chk
      AST_TOKEN_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        stageHit[k-1] |=> (stageHit[k] == !freezeIn[k])); // R4

      AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (rst)
        !stageHit[k-1] |=> !stageHit[k]); // R5
    end
  endgenerate

endmodule

bind stage_slice_tracker slice_tracker_chk #(
  .WORD_W  (WORD_W),
  .OP_LSB  (OP_LSB),
  .OP_W    (OP_W),
  .OP_MATCH(OP_MATCH),
  .OP_MASK (OP_MASK)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .instrWord(instrWord),
  .flushPipe(flushPipe),
  .freezeIn (freezeIn),
  .stageHit (stageHit),
  .outEnable(outEnable)
);

// File: tb/stage_slice_tracker_tb_top.sv
module stage_slice_tracker_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrWord = '0;
  logic        flushPipe = 1'b0;
  logic [4:0]  freezeIn = '0;
  logic [4:0]  stageHit;
  logic [4:0]  outEnable;

  int checks = 0;
  int fails  = 0;

  logic [4:0]  prevExp = '0;
  logic [31:0] w1 = '0;
  logic [31:0] w2 = '0;
  logic [31:0] fpAccFull  = '0;
  logic [31:0] fpAccGated = '0;

  always #4 clk = ~clk;   // 125 MHz

  stage_slice_tracker dut_i (
    .clk      (clk),
    .rst      (rst),
    .instrWord(instrWord),
    .flushPipe(flushPipe),
    .freezeIn (freezeIn),
    .stageHit (stageHit),
    .outEnable(outEnable)
  );

  function automatic logic isTracked(input logic [31:0] w);
    return w[31:26] == 6'b111000;
  endfunction

  function automatic logic isFp(input logic [31:0] w);
    return w[31:26] == 6'b110010;
  endfunction

  function automatic logic [4:0] expFlags(input logic [31:0] w, input logic fl,
                                          input logic [4:0] fz, input logic r,
                                          input logic [4:0] prev);
    logic [4:0] e;
    e[0] = isTracked(w) & ~r & ~fl & ~fz[0];
    for (int k = 1; k < 5; k++) e[k] = prev[k-1] & ~r & ~fz[k];
    return e;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [31:0] w, input logic fl, input logic [4:0] fz,
                      input logic r, input string tag);
    logic [4:0] e;
    @(negedge clk);
    instrWord = w; flushPipe = fl; freezeIn = fz; rst = r;
    #2;
    e = expFlags(w, fl, fz, r, prevExp);
    chk(tag, {27'd0, stageHit}, {27'd0, e});
    chk("R6 enable", {27'd0, outEnable}, {27'd0, ~e});
    if (isFp(w2)) fpAccFull = fpAccFull + {16'd0, w2[15:0]};
    if (isFp(w2) && outEnable[2]) fpAccGated = fpAccGated + {16'd0, w2[15:0]};
    w2 = w1; w1 = w;
    prevExp = e;
  endtask

  localparam logic [31:0] TRK   = {6'b111000, 26'h0000123};
  localparam logic [31:0] OTHER = {6'b111001, 26'h0000123};

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset holds everything quiet, even with a tracked opcode present
    step(TRK, 1'b0, 5'b0, 1'b1, "R1 reset");
    step(TRK, 1'b0, 5'b0, 1'b1, "R1 reset");
    step('0, 1'b0, 5'b0, 1'b0, "R1 after reset");
    // R2/R4: single token walks all five stages
    step(TRK, 1'b0, 5'b0, 1'b0, "R2 fetch hit");
    for (int i = 0; i < 5; i++) step('0, 1'b0, 5'b0, 1'b0, "R4 walk");
    // R2: neighbouring opcode is not tracked
    step(OTHER, 1'b0, 5'b0, 1'b0, "R2 other opcode");
    // R3: flush and fetch freeze block entry
    step(TRK, 1'b1, 5'b0, 1'b0, "R3 flush");
    step(TRK, 1'b0, 5'b00001, 1'b0, "R3 fetch freeze");
    step('0, 1'b0, 5'b0, 1'b0, "R3 nothing entered");
    step('0, 1'b0, 5'b0, 1'b0, "R3 nothing entered");
    // R7: back-to-back tokens
    step(TRK, 1'b0, 5'b0, 1'b0, "R7 burst");
    step(TRK, 1'b0, 5'b0, 1'b0, "R7 burst");
    step(TRK, 1'b0, 5'b0, 1'b0, "R7 burst");
    step('0, 1'b0, 5'b0, 1'b0, "R7 burst");
    // R5: freeze execute while tokens sit in decode and execute
    step(TRK, 1'b0, 5'b0, 1'b0, "R5 setup");
    step(TRK, 1'b0, 5'b0, 1'b0, "R5 setup");
    step('0, 1'b0, 5'b00100, 1'b0, "R5 exec frozen");
    step('0, 1'b0, 5'b0, 1'b0, "R5 drop propagates");
    step('0, 1'b0, 5'b0, 1'b0, "R5 drop propagates");
    step('0, 1'b0, 5'b0, 1'b0, "R5 drop propagates");
    // R1: reset in mid-flight clears held state
    step(TRK, 1'b0, 5'b0, 1'b0, "R1 preload");
    step(TRK, 1'b0, 5'b0, 1'b1, "R1 mid-flight reset");
    step('0, 1'b0, 5'b0, 1'b0, "R1 no stale flags");
    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] w;
      logic [4:0]  fz;
      int sel;
      sel = $urandom % 8;
      w = $urandom;
      if (sel < 3)      w[31:26] = 6'b111000;
      else if (sel < 5) w[31:26] = 6'b110010;
      for (int k = 0; k < 5; k++) fz[k] = ($urandom % 8) == 0;
      step(w, ($urandom % 10) == 0, fz, ($urandom % 250) == 0, "R4 random");
    end
    chk("R6 gated datapath equal", fpAccGated, fpAccFull);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule